// File: doc/BRIEF.md
# Prioritized Power-Mode Trigger Controller

This block holds the operating mode of a power-management controller and decides, once per clock, which of its competing wake, sleep and software triggers to act on. The four modes are STANDBY, ACTIVE, MCU_ONLY and SUSPEND (retention). Each trigger has a fixed priority number and is legal only in some modes. The lowest-numbered legal trigger wins. Its destination mode is stored, and a one-cycle sequence-start pulse with an encoded sequence number tells the rail sequencer which power-up or power-down sequence to run.

Each effective sleep input is the OR of a pin and a register bit. Wake pins and sleep-pair changes are edge events. The "both sleep inputs high" condition is a level, and it keeps blocking lower-priority requests for as long as it holds. Software commands are single-shot bits gated by the sleep mask bits. They are written by a strobe, evaluated in the next cycle and then dropped. Two of them cause no mode change: one pulses a CRC-enable flag alongside whatever else happens, and the other pulses an update-prepare flag.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is STANDBY and `seq_go_o`, `seq_id_o`, `crc_en_o` and `upd_prep_o` are all 0.
- R2: Mode codes are STANDBY=0, ACTIVE=1, MCU_ONLY=2, SUSPEND=3. Sequence codes are to-active=1, to-mcu=2, to-retention=3, to-standby=4 and none=0. `seq_go_o` is high for one cycle, in the first cycle the new mode shows on `mode_o`, and only when the mode actually changes.
- R3: An ON request pulse (priority 14), a rising edge on `wake1_i` (15) or both effective sleep inputs high (16, level) moves the block to ACTIVE from any mode.
- R4: An MCU request pulse (17) or a rising edge on `wake2_i` (18) moves the block to MCU_ONLY from any mode. The sleep pair changing to sleep1=0/sleep2=1 (19) does the same, but only from ACTIVE, MCU_ONLY or SUSPEND.
- R5: From ACTIVE or MCU_ONLY only, the sleep pair changing to 0/0 (20) or to 1/0 (21) moves the block to SUSPEND.
- R6: The standby command (22) moves the block to STANDBY from STANDBY, ACTIVE or MCU_ONLY, and is ignored in SUSPEND.
- R7: When several legal triggers are present, only the lowest-numbered one is acted on. A winner whose destination is the current mode still blocks every lower one (for example, in ACTIVE with both sleep inputs high, MCU and wake2 requests do nothing).
- R8: Each effective sleep input is its pin OR its register bit.
- R9: Sleep-derived triggers (16, 19, 20, 21) are ignored while either mask bit is set. The standby (22) and update (23) commands are ignored unless both mask bits are set.
- R10: The CRC command (13) is immediate and re-entrant. In ACTIVE or MCU_ONLY it pulses `crc_en_o` for one cycle, even in the cycle in which another trigger changes the mode. It never changes the mode itself.
- R11: The update command (23), when it wins in ACTIVE or MCU_ONLY, pulses `upd_prep_o` for one cycle without a mode change.
- R12: A command strobe is acted on at the clock edge after the strobe and is then discarded. A command that was not acted on has no later effect.
- R13: Wake and sleep-pair edge events act once. A wake pin held high does not fire again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| on_req_i | input | 1 | ON request pulse |
| mcu_req_i | input | 1 | MCU-only request pulse |
| wake1_i | input | 1 | Wake pin toward ACTIVE |
| wake2_i | input | 1 | Wake pin toward MCU_ONLY |
| slp1_pin_i | input | 1 | Sleep input 1, pin |
| slp1_reg_i | input | 1 | Sleep input 1, register bit |
| slp2_pin_i | input | 1 | Sleep input 2, pin |
| slp2_reg_i | input | 1 | Sleep input 2, register bit |
| slp1_mask_i | input | 1 | Mask for sleep input 1 |
| slp2_mask_i | input | 1 | Mask for sleep input 2 |
| cmd_stby_i | input | 1 | Standby command strobe |
| cmd_crc_i | input | 1 | CRC-enable command strobe |
| cmd_upd_i | input | 1 | Update-prepare command strobe |
| mode_o | output | 2 | Current mode |
| seq_go_o | output | 1 | Sequence-start pulse |
| seq_id_o | output | 3 | Sequence number of the pulse |
| crc_en_o | output | 1 | CRC-enable pulse |
| upd_prep_o | output | 1 | Update-prepare pulse |

## Verification
The immediate CRC command and an arbitrated mode change can land in the same cycle. The bench provokes this by strobing the CRC command and then raising `wake2_i` one cycle later, so that both are evaluated at the same edge while the block is in ACTIVE. The case is judged by checking that `crc_en_o`, the new MCU_ONLY mode and a to-mcu `seq_go_o` pulse all appear in the same output cycle and are all gone in the next one.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_MCU     = 2'd2,
        ST_SUSPEND = 2'd3
    } pmode_e;

    typedef enum logic [2:0] {
        SQ_NONE    = 3'd0,
        SQ_ACTIVE  = 3'd1,
        SQ_MCU     = 3'd2,
        SQ_RETAIN  = 3'd3,
        SQ_STANDBY = 3'd4
    } seq_e;

    // Arbitrated triggers, index order equals priority order (ids 14..23)
    localparam int NUM_TRIG    = 10;
    localparam int NUM_HW_TRIG = 8;
    localparam int T_ON      = 0;
    localparam int T_WAKE1   = 1;
    localparam int T_SLP_HH  = 2;
    localparam int T_MCU     = 3;
    localparam int T_WAKE2   = 4;
    localparam int T_SLP_LH  = 5;
    localparam int T_SLP_LL  = 6;
    localparam int T_SLP_HL  = 7;
    localparam int T_SW_STBY = 8;
    localparam int T_SW_UPD  = 9;

    // Pending software command bits
    localparam int NUM_CMD = 3;
    localparam int P_STBY  = 0;
    localparam int P_CRC   = 1;
    localparam int P_UPD   = 2;

    typedef struct packed {
        pmode_e               mode;
        logic                 seq_go;
        seq_e                 seq_id;
        logic                 crc;
        logic                 upd;
        logic [NUM_CMD-1:0]   pend;
    } ctl_t;

    function automatic logic trig_allowed(input int idx, input pmode_e st);
        logic in_run;
        in_run = (st == ST_ACTIVE) || (st == ST_MCU);
        case (idx)
            T_ON, T_WAKE1, T_SLP_HH, T_MCU, T_WAKE2: return 1'b1;
            T_SLP_LH:                                return st != ST_STANDBY;
            T_SLP_LL, T_SLP_HL, T_SW_UPD:            return in_run;
            T_SW_STBY:                               return st != ST_SUSPEND;
            default:                                 return 1'b0;
        endcase
    endfunction

    function automatic pmode_e trig_dest(input int idx, input pmode_e cur);
        case (idx)
            T_ON, T_WAKE1, T_SLP_HH: return ST_ACTIVE;
            T_MCU, T_WAKE2, T_SLP_LH: return ST_MCU;
            T_SLP_LL, T_SLP_HL:       return ST_SUSPEND;
            T_SW_STBY:                return ST_STANDBY;
            default:                  return cur;
        endcase
    endfunction

    function automatic seq_e seq_for(input pmode_e dest);
        case (dest)
            ST_ACTIVE:  return SQ_ACTIVE;
            ST_MCU:     return SQ_MCU;
            ST_SUSPEND: return SQ_RETAIN;
            default:    return SQ_STANDBY;
        endcase
    endfunction

endpackage

// File: rtl/pmc_trig_detect.sv
module pmc_trig_detect
    import pmc_pkg::*;
(
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   on_req_i,
    input  logic                   mcu_req_i,
    input  logic                   wake1_i,
    input  logic                   wake2_i,
    input  logic                   slp1_pin_i,
    input  logic                   slp1_reg_i,
    input  logic                   slp2_pin_i,
    input  logic                   slp2_reg_i,
    input  logic                   slp1_mask_i,
    input  logic                   slp2_mask_i,
    output logic [NUM_HW_TRIG-1:0] hw_raw_o
);

    typedef struct packed {
        logic wake1;
        logic wake2;
        logic slp1;
        logic slp2;
    } prev_t;

    prev_t prev_d, prev_q;
    logic  s1, s2, sleep_en, pair_changed;

    always_comb begin
        s1           = slp1_pin_i | slp1_reg_i;
        s2           = slp2_pin_i | slp2_reg_i;
        sleep_en     = !slp1_mask_i && !slp2_mask_i;
        pair_changed = ({s1, s2} != {prev_q.slp1, prev_q.slp2});

        prev_d.wake1 = wake1_i;
        prev_d.wake2 = wake2_i;
        prev_d.slp1  = s1;
        prev_d.slp2  = s2;

        hw_raw_o           = '0;
        hw_raw_o[T_ON]     = on_req_i;
        hw_raw_o[T_WAKE1]  = wake1_i && !prev_q.wake1;
        hw_raw_o[T_SLP_HH] = sleep_en && s1 && s2;
        hw_raw_o[T_MCU]    = mcu_req_i;
        hw_raw_o[T_WAKE2]  = wake2_i && !prev_q.wake2;
        hw_raw_o[T_SLP_LH] = sleep_en && pair_changed && !s1 &&  s2;
        hw_raw_o[T_SLP_LL] = sleep_en && pair_changed && !s1 && !s2;
        hw_raw_o[T_SLP_HL] = sleep_en && pair_changed &&  s1 && !s2;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= prev_d;
    end

    // A wake edge event never repeats in the following cycle
    assert_wake1_once_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hw_raw_o[T_WAKE1] |=> !hw_raw_o[T_WAKE1]);
    assert_wake2_once_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hw_raw_o[T_WAKE2] |=> !hw_raw_o[T_WAKE2]);
    // Masked sleep inputs produce no sleep-derived trigger
    assert_sleep_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slp1_mask_i || slp2_mask_i) |->
        !(hw_raw_o[T_SLP_HH] || hw_raw_o[T_SLP_LH] || hw_raw_o[T_SLP_LL] || hw_raw_o[T_SLP_HL]));

endmodule

// File: rtl/pmc_prio_pick.sv
module pmc_prio_pick #(
    parameter int N  = 10,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);

    logic [N-1:0] grant;

    // Lowest index wins: scan from the top so the lowest assignment sticks
    always_comb begin
        idx_o = '0;
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IW'(i);
                grant = '0;
                grant[i] = 1'b1;
            end
        end
        any_o = |req_i;
    end

    always_comb begin
        assert_grant_onehot_R7: assert ($onehot0(grant));
        assert_grant_any_R7: assert ((|grant) == any_o);
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       on_req_i,
    input  logic       mcu_req_i,
    input  logic       wake1_i,
    input  logic       wake2_i,
    input  logic       slp1_pin_i,
    input  logic       slp1_reg_i,
    input  logic       slp2_pin_i,
    input  logic       slp2_reg_i,
    input  logic       slp1_mask_i,
    input  logic       slp2_mask_i,
    input  logic       cmd_stby_i,
    input  logic       cmd_crc_i,
    input  logic       cmd_upd_i,
    output logic [1:0] mode_o,
    output logic       seq_go_o,
    output logic [2:0] seq_id_o,
    output logic       crc_en_o,
    output logic       upd_prep_o
);

    localparam int IW = $clog2(NUM_TRIG);

    ctl_t                 ctl_d, ctl_q;
    logic [NUM_HW_TRIG-1:0] hw_raw;
    logic [NUM_TRIG-1:0]  raw, valid;
    logic                 win_any;
    logic [IW-1:0]        win_idx;
    logic                 mask_both, in_run;
    pmode_e               dest;

    pmc_trig_detect i_detect (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .on_req_i    (on_req_i),
        .mcu_req_i   (mcu_req_i),
        .wake1_i     (wake1_i),
        .wake2_i     (wake2_i),
        .slp1_pin_i  (slp1_pin_i),
        .slp1_reg_i  (slp1_reg_i),
        .slp2_pin_i  (slp2_pin_i),
        .slp2_reg_i  (slp2_reg_i),
        .slp1_mask_i (slp1_mask_i),
        .slp2_mask_i (slp2_mask_i),
        .hw_raw_o    (hw_raw)
    );

    assign mask_both = slp1_mask_i && slp2_mask_i;
    assign in_run    = (ctl_q.mode == ST_ACTIVE) || (ctl_q.mode == ST_MCU);
    assign raw       = {ctl_q.pend[P_UPD] && mask_both,
                        ctl_q.pend[P_STBY] && mask_both,
                        hw_raw};

    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_gate
        assign valid[g] = raw[g] && trig_allowed(g, ctl_q.mode);
    end

    pmc_prio_pick #(.N(NUM_TRIG)) i_pick (
        .req_i (valid),
        .any_o (win_any),
        .idx_o (win_idx)
    );

    always_comb begin
        ctl_d             = ctl_q;
        ctl_d.seq_go      = 1'b0;
        ctl_d.seq_id      = SQ_NONE;
        ctl_d.crc         = ctl_q.pend[P_CRC] && in_run;
        ctl_d.upd         = 1'b0;
        ctl_d.pend[P_STBY] = cmd_stby_i;
        ctl_d.pend[P_CRC]  = cmd_crc_i;
        ctl_d.pend[P_UPD]  = cmd_upd_i;

        dest = trig_dest(int'(win_idx), ctl_q.mode);
        if (win_any) begin
            if (int'(win_idx) == T_SW_UPD) ctl_d.upd = 1'b1;
            if (dest != ctl_q.mode) begin
                ctl_d.mode   = dest;
                ctl_d.seq_go = 1'b1;
                ctl_d.seq_id = seq_for(dest);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q        <= '0;
            ctl_q.mode   <= ST_STANDBY;
            ctl_q.seq_id <= SQ_NONE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mode_o     = ctl_q.mode;
    assign seq_go_o   = ctl_q.seq_go;
    assign seq_id_o   = ctl_q.seq_id;
    assign crc_en_o   = ctl_q.crc;
    assign upd_prep_o = ctl_q.upd;

    assert_go_on_change_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_go_o |-> (mode_o != $past(mode_o)));
    assert_change_has_go_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o != $past(mode_o)) |-> seq_go_o);
    assert_idle_id_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !seq_go_o |-> (seq_id_o == 3'd0));
    assert_retain_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_go_o && mode_o == 2'd3) |->
        ($past(mode_o) == 2'd1 || $past(mode_o) == 2'd2));
    assert_standby_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_go_o && seq_id_o == 3'd4) |-> $past(slp1_mask_i && slp2_mask_i));
    assert_crc_in_run_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        crc_en_o |-> ($past(mode_o) == 2'd1 || $past(mode_o) == 2'd2));
    assert_upd_no_change_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_prep_o |-> (!seq_go_o && $past(cmd_upd_i, 2)));
    assert_cmd_once_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        crc_en_o && !$past(cmd_crc_i) |=> !crc_en_o);

endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG_CYCLES = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic on_req = 0, mcu_req = 0, wake1 = 0, wake2 = 0;
    logic slp1_pin = 0, slp1_reg = 0, slp2_pin = 0, slp2_reg = 0;
    logic slp1_mask = 0, slp2_mask = 0;
    logic cmd_stby = 0, cmd_crc = 0, cmd_upd = 0;
    logic [1:0] mode;
    logic       seq_go;
    logic [2:0] seq_id;
    logic       crc_en, upd_prep;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwr_mode_ctrl i_pwr_mode_ctrl (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .on_req_i    (on_req),
        .mcu_req_i   (mcu_req),
        .wake1_i     (wake1),
        .wake2_i     (wake2),
        .slp1_pin_i  (slp1_pin),
        .slp1_reg_i  (slp1_reg),
        .slp2_pin_i  (slp2_pin),
        .slp2_reg_i  (slp2_reg),
        .slp1_mask_i (slp1_mask),
        .slp2_mask_i (slp2_mask),
        .cmd_stby_i  (cmd_stby),
        .cmd_crc_i   (cmd_crc),
        .cmd_upd_i   (cmd_upd),
        .mode_o      (mode),
        .seq_go_o    (seq_go),
        .seq_id_o    (seq_id),
        .crc_en_o    (crc_en),
        .upd_prep_o  (upd_prep)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_out(input string req, input int st, input int go, input int id,
                              input int crc, input int upd);
        chk(req, "mode", int'(mode), st);
        chk(req, "seq_go", int'(seq_go), go);
        chk(req, "seq_id", int'(seq_id), id);
        chk(req, "crc_en", int'(crc_en), crc);
        chk(req, "upd_prep", int'(upd_prep), upd);
    endtask

    // Advance one edge; inputs change and outputs are sampled 1ns after it
    task automatic step();
        @(posedge clk);
        #1ns;
    endtask

    task automatic reset_dut();
        rst_n = 0;
        {on_req, mcu_req, wake1, wake2} = '0;
        {slp1_pin, slp1_reg, slp2_pin, slp2_reg, slp1_mask, slp2_mask} = '0;
        {cmd_stby, cmd_crc, cmd_upd} = '0;
        repeat (3) step();
        rst_n = 1;
        step();
    endtask

    task automatic go_active();
        on_req = 1; step(); on_req = 0;
    endtask

    task automatic t_reset();
        reset_dut();
        expect_out("R1", 0, 0, 0, 0, 0);
        step();
        expect_out("R1", 0, 0, 0, 0, 0);
    endtask

    task automatic t_to_active();
        reset_dut();
        go_active();
        expect_out("R3", 1, 1, 1, 0, 0);
        step();
        expect_out("R2", 1, 0, 0, 0, 0);
        on_req = 1; step(); on_req = 0;
        expect_out("R2", 1, 0, 0, 0, 0);
        mcu_req = 1; step(); mcu_req = 0;
        expect_out("R4", 2, 1, 2, 0, 0);
        wake1 = 1; step();
        expect_out("R3", 1, 1, 1, 0, 0);
    endtask

    task automatic t_to_mcu();
        reset_dut();
        wake2 = 1; step();
        expect_out("R4", 2, 1, 2, 0, 0);
        reset_dut();
        slp2_pin = 1; step();
        expect_out("R4", 0, 0, 0, 0, 0);  // pair 0/1 not legal in STANDBY
        go_active();
        expect_out("R3", 1, 1, 1, 0, 0);
        slp2_pin = 0; step();
        expect_out("R5", 3, 1, 3, 0, 0);
        slp2_pin = 1; step();
        expect_out("R4", 2, 1, 2, 0, 0);
    endtask

    task automatic t_retention();
        reset_dut();
        go_active();
        slp1_pin = 1; step();
        expect_out("R5", 3, 1, 3, 0, 0);
        slp1_pin = 0; step();
        expect_out("R5", 3, 0, 0, 0, 0);  // pair 0/0 not legal in SUSPEND
        slp1_mask = 1; slp2_mask = 1; step();
        cmd_stby = 1; step(); cmd_stby = 0; step();
        expect_out("R6", 3, 0, 0, 0, 0);
    endtask

    task automatic t_priority();
        reset_dut();
        slp1_reg = 1; slp2_pin = 1; step();
        expect_out("R8", 1, 1, 1, 0, 0);
        step();
        expect_out("R7", 1, 0, 0, 0, 0);
        mcu_req = 1; step(); mcu_req = 0;
        expect_out("R7", 1, 0, 0, 0, 0);
        wake2 = 1; step();
        expect_out("R7", 1, 0, 0, 0, 0);
        slp1_reg = 0; step();
        expect_out("R4", 2, 1, 2, 0, 0);
        reset_dut();
        on_req = 1; mcu_req = 1; step(); on_req = 0; mcu_req = 0;
        expect_out("R7", 1, 1, 1, 0, 0);
        reset_dut();
        mcu_req = 1; wake1 = 1; step(); mcu_req = 0;
        expect_out("R7", 1, 1, 1, 0, 0);
    endtask

    task automatic t_masks();
        reset_dut();
        go_active();
        cmd_stby = 1; step(); cmd_stby = 0; step();
        expect_out("R9", 1, 0, 0, 0, 0);
        slp1_mask = 1; slp2_mask = 1; step(); step();
        expect_out("R12", 1, 0, 0, 0, 0);
        cmd_stby = 1; step(); cmd_stby = 0;
        expect_out("R12", 1, 0, 0, 0, 0);
        step();
        expect_out("R6", 0, 1, 4, 0, 0);
        slp1_pin = 1; slp2_pin = 1; step(); step();
        expect_out("R9", 0, 0, 0, 0, 0);
    endtask

    task automatic t_crc();
        reset_dut();
        cmd_crc = 1; step(); cmd_crc = 0; step();
        expect_out("R10", 0, 0, 0, 0, 0);
        go_active();
        cmd_crc = 1; step(); cmd_crc = 0;
        expect_out("R12", 1, 0, 0, 0, 0);
        step();
        expect_out("R10", 1, 0, 0, 1, 0);
        step();
        expect_out("R10", 1, 0, 0, 0, 0);
        cmd_crc = 1; step(); cmd_crc = 0; wake2 = 1; step();
        expect_out("R10", 2, 1, 2, 1, 0);
        step();
        expect_out("R10", 2, 0, 0, 0, 0);
    endtask

    task automatic t_update();
        reset_dut();
        slp1_mask = 1; slp2_mask = 1;
        cmd_upd = 1; step(); cmd_upd = 0; step();
        expect_out("R11", 0, 0, 0, 0, 0);
        go_active();
        cmd_upd = 1; step(); cmd_upd = 0; step();
        expect_out("R11", 1, 0, 0, 0, 1);
        step();
        expect_out("R11", 1, 0, 0, 0, 0);
        cmd_upd = 1; cmd_stby = 1; step(); cmd_upd = 0; cmd_stby = 0; step();
        expect_out("R7", 0, 1, 4, 0, 0);
    endtask

    task automatic t_edges();
        reset_dut();
        wake1 = 1; step();
        expect_out("R13", 1, 1, 1, 0, 0);
        mcu_req = 1; step(); mcu_req = 0;
        expect_out("R13", 2, 1, 2, 0, 0);
        step();
        expect_out("R13", 2, 0, 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_to_active();
        t_to_mcu();
        t_retention();
        t_priority();
        t_masks();
        t_crc();
        t_update();
        t_edges();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule